// File: doc/BRIEF.md
# Read-Data CRC-8 Appender

This block sits on the serial transmit path of a device that answers read requests. An upstream serializer hands it one data bit per strobe, least significant bit of each byte first. The block forwards every accepted bit to its serial output one clock later. At the same time it folds that bit into an 8-stage LFSR that implements the polynomial x^8 + x^5 + x^4 + 1.

Each transaction begins with a start pulse, which carries the transaction's opcode. The start pulse clears the LFSR to zero and latches whether a checksum is wanted. Only the read opcode binary 10 asks for one.

For that opcode, the bit flagged as the last of the final byte is followed directly by the eight LFSR bits, least significant first, on consecutive cycles. While those bits are sent, the LFSR is frozen. A one-cycle done pulse marks the final bit of the stream: the last CRC bit, or the last data bit when no CRC is attached.

Top module: `rdcrc_appender`

## Requirements
- R1: After synchronous reset, `ser_vld_o` and `done_o` are 0.
- R2: A bit presented with `bit_vld_i` high, outside the append phase, appears on `ser_out_o` with `ser_vld_o` high on the next clock cycle.
- R3: The CRC register is updated per accepted bit as the LSB-first serial form of x^8 + x^5 + x^4 + 1. The update takes feedback = stage0 XOR bit, shifts right, and XORs 0x8C into the register when the feedback is 1.
- R4: A `start_i` pulse clears the CRC register to zero, so each transaction's CRC depends only on its own data.
- R5: A CRC is appended only when `opcode_i` sampled at `start_i` equals binary 10. Opcodes 00, 01 and 11 produce the data bits only.
- R6: With a CRC, the eight CRC bits follow the last data bit on the eight consecutive cycles right after it, bit 0 first, with `ser_vld_o` high.
- R7: Bits strobed in while the CRC is being shifted out are ignored. They are not echoed and they do not change the CRC value sent.
- R8: `done_o` is high for exactly one cycle per transaction, in the same cycle as the final output bit of the stream.
- R9: The appended CRC for the single byte 0x00 is 0x00, and for the single byte 0x01 it is 0x5E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transaction start; clears CRC and samples opcode |
| opcode_i | input | 2 | Instruction opcode, sampled with start_i |
| bit_vld_i | input | 1 | Strobe for bit_in_i |
| bit_in_i | input | 1 | Serial data bit, LSB of each byte first |
| last_i | input | 1 | Marks the last bit of the final byte |
| ser_out_o | output | 1 | Serial output bit |
| ser_vld_o | output | 1 | Strobe for ser_out_o |
| done_o | output | 1 | One-cycle pulse with the final stream bit |

## Verification
The assertions rely on a few input rules. `start_i` is never raised while the CRC bits are being shifted out. It never coincides with a data strobe. Every transaction ends with exactly one bit marked by `last_i`.

The stimulus meets these rules. It raises `start_i` alone, one cycle before the first data bit. It flags the final bit of the byte count it drives. It starts the next transaction only after the done pulse has been seen.

The only strobes that fall inside the append window are the deliberate ones used to show that such bits are discarded.

// File: rtl/rdcrc_pkg.sv
package rdcrc_pkg;
  typedef enum logic {PH_STREAM = 1'b0, PH_APPEND = 1'b1} phase_t;
endpackage

// File: rtl/rdcrc_lfsr.sv
module rdcrc_lfsr #(
  parameter int              W        = 8,
  parameter logic [W-1:0]    POLY_REF = 8'h8C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] base;
  logic [W-1:0] nxt;
  logic         fb;

  always_comb begin
    base = clr ? '0 : q;
    fb   = base[0] ^ din;
    nxt  = (base >> 1) ^ (fb ? POLY_REF : '0);
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= nxt;
    else if (clr)      q <= '0;
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !shift_en) |=> (q == '0));
endmodule

// File: rtl/rdcrc_seq.sv
module rdcrc_seq
  import rdcrc_pkg::*;
#(
  parameter int             W      = 8,
  parameter int             OPW    = 2,
  parameter logic [OPW-1:0] CRC_OP = 2'b10,
  localparam int            CW     = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic           bit_vld,
  input  logic           last,
  output phase_t         phase,
  output logic [CW-1:0]  cnt,
  output logic           en_now,
  output logic           accept,
  output logic           shift_en
);
  logic crc_en_q;

  assign en_now   = start ? (opcode == CRC_OP) : crc_en_q;
  assign accept   = bit_vld && (phase == PH_STREAM);
  assign shift_en = accept && en_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_en_q <= 1'b0;
      phase    <= PH_STREAM;
      cnt      <= '0;
    end else begin
      if (start) crc_en_q <= (opcode == CRC_OP);
      if (phase == PH_APPEND) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W-1)) begin
          phase <= PH_STREAM;
          cnt   <= '0;
        end
      end else if (shift_en && last) begin
        phase <= PH_APPEND;
        cnt   <= '0;
      end
    end
  end

  p_append_len_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_APPEND && cnt != CW'(W-1)) |=>
      (phase == PH_APPEND && cnt == $past(cnt) + 1'b1));
  p_noappend_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STREAM && !en_now) |=> (phase == PH_STREAM));
endmodule

// File: rtl/rdcrc_out.sv
module rdcrc_out #(
  parameter int  W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          append,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  crc,
  input  logic          accept,
  input  logic          bit_in,
  input  logic          last,
  input  logic          en_now,
  output logic          ser_out,
  output logic          ser_vld,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= 1'b0;
      ser_vld <= 1'b0;
      done    <= 1'b0;
    end else if (append) begin
      ser_out <= crc[cnt];
      ser_vld <= 1'b1;
      done    <= (cnt == CW'(W-1));
    end else begin
      ser_out <= accept ? bit_in : 1'b0;
      ser_vld <= accept;
      done    <= accept && last && !en_now;
    end
  end

  p_done_vld_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ser_vld);
endmodule

// File: rtl/rdcrc_appender.sv
module rdcrc_appender
  import rdcrc_pkg::*;
#(
  parameter int             W        = 8,
  parameter logic [W-1:0]   POLY_REF = 8'h8C,
  parameter int             OPW      = 2,
  parameter logic [OPW-1:0] CRC_OP   = 2'b10,
  localparam int            CW       = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [OPW-1:0] opcode_i,
  input  logic           bit_vld_i,
  input  logic           bit_in_i,
  input  logic           last_i,
  output logic           ser_out_o,
  output logic           ser_vld_o,
  output logic           done_o
);
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          en_now, accept, shift_en;
  logic [W-1:0]  crc_q;

  rdcrc_seq #(.W(W), .OPW(OPW), .CRC_OP(CRC_OP)) seq_i (
    .clk(clk), .rst(rst), .start(start_i), .opcode(opcode_i),
    .bit_vld(bit_vld_i), .last(last_i), .phase(phase), .cnt(cnt),
    .en_now(en_now), .accept(accept), .shift_en(shift_en)
  );

  rdcrc_lfsr #(.W(W), .POLY_REF(POLY_REF)) lfsr_i (
    .clk(clk), .rst(rst), .clr(start_i), .shift_en(shift_en),
    .din(bit_in_i), .q(crc_q)
  );

  rdcrc_out #(.W(W)) out_i (
    .clk(clk), .rst(rst), .append(phase == PH_APPEND), .cnt(cnt),
    .crc(crc_q), .accept(accept), .bit_in(bit_in_i), .last(last_i),
    .en_now(en_now), .ser_out(ser_out_o), .ser_vld(ser_vld_o), .done(done_o)
  );

  p_echo_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && phase == PH_STREAM) |=> (ser_vld_o && ser_out_o == $past(bit_in_i)));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_APPEND && !start_i) |=> $stable(crc_q));
endmodule

// File: tb/rdcrc_appender_tb_top.sv
`timescale 1ns/1ps
module rdcrc_appender_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, bit_vld_i = 1'b0, bit_in_i = 1'b0, last_i = 1'b0;
  logic [1:0] opcode_i = 2'b00;
  logic ser_out_o, ser_vld_o, done_o;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic cap [0:63];
  int   ncap = 0, ndone = 0, done_idx = -1;

  always #2 clk = ~clk;

  rdcrc_appender dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .bit_vld_i(bit_vld_i), .bit_in_i(bit_in_i), .last_i(last_i),
    .ser_out_o(ser_out_o), .ser_vld_o(ser_vld_o), .done_o(done_o)
  );

  // {opcode, byte count, data bytes little-endian}
  localparam logic [37:0] VEC [0:6] = '{
    {2'b10, 4'd1, 32'h0000_00A5},
    {2'b10, 4'd2, 32'h0000_3C7F},
    {2'b10, 4'd4, 32'hDEAD_BEEF},
    {2'b10, 4'd3, 32'h00FF_0080},
    {2'b00, 4'd2, 32'h0000_1234},
    {2'b01, 4'd1, 32'h0000_00C3},
    {2'b11, 4'd3, 32'h0055_AA0F}
  };

  always @(negedge clk) begin
    cycles++;
    if (!rst && ser_vld_o && ncap < 64) begin
      cap[ncap] = ser_out_o;
      if (done_o) done_idx = ncap;
      ncap++;
    end
    if (!rst && done_o) ndone++;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
    summary();
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // Stage-by-stage model of the 8-stage register, LSB-first input.
  function automatic logic [7:0] ref_crc(input logic [31:0] d, input int nb);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 8*nb; i++) begin
      logic fb;
      fb = s[0] ^ d[i];
      s  = {fb, s[7], s[6], s[5], s[4] ^ fb, s[3] ^ fb, s[2], s[1]};
    end
    return s;
  endfunction

  task automatic run(input logic [1:0] op, input int nb, input logic [31:0] d,
                     input bit inject, output logic [7:0] got);
    int exp_len;
    int bad;
    ncap = 0; ndone = 0; done_idx = -1; got = 8'h00;
    @(negedge clk); start_i = 1'b1; opcode_i = op;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 8*nb; i++) begin
      bit_vld_i = 1'b1; bit_in_i = d[i]; last_i = (i == 8*nb-1);
      @(negedge clk);
    end
    last_i = 1'b0;
    if (inject && op == 2'b10) begin
      for (int k = 0; k < 8; k++) begin
        bit_in_i = ~bit_in_i;
        @(negedge clk);
      end
    end
    bit_vld_i = 1'b0; bit_in_i = 1'b0;
    repeat (12) @(negedge clk);
    exp_len = 8*nb + ((op == 2'b10) ? 8 : 0);
    chk(ncap == exp_len, "R5/R6/R7 stream length", ncap, exp_len);
    bad = 0;
    for (int i = 0; i < 8*nb && i < ncap; i++) if (cap[i] !== d[i]) bad++;
    chk(bad == 0, "R2 data echo mismatches", bad, 0);
    if (op == 2'b10) begin
      for (int k = 0; k < 8; k++) if (8*nb+k < ncap) got[k] = cap[8*nb+k];
      chk(got == ref_crc(d, nb), "R3/R4/R6 crc value", got, ref_crc(d, nb));
    end
    chk(ndone == 1 && done_idx == exp_len-1, "R8 done count/index",
        ndone*256 + done_idx, 256 + exp_len - 1);
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    chk(ser_vld_o == 1'b0 && done_o == 1'b0, "R1 reset outputs",
        {ser_vld_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int v = 0; v < 7; v++)
      run(VEC[v][37:36], int'(VEC[v][35:32]), VEC[v][31:0], 1'b0, got);
    run(2'b10, 1, 32'h00, 1'b0, got);
    chk(got == 8'h00, "R9 crc of 0x00", got, 8'h00);
    run(2'b10, 1, 32'h01, 1'b0, got);
    chk(got == 8'h5E, "R9 crc of 0x01", got, 8'h5E);
    run(2'b10, 2, 32'h0000_9C41, 1'b1, got);
    chk(got == ref_crc(32'h0000_9C41, 2), "R7 crc unaffected by injected bits",
        got, ref_crc(32'h0000_9C41, 2));
    run(2'b10, 1, 32'h01, 1'b0, got);
    chk(got == 8'h5E, "R4 crc cleared between transactions", got, 8'h5E);
    summary();
  end
endmodule